// File: doc/BRIEF.md
# Byte-wide fuse array read sequencer

This block reads a run of bytes out of a one-time-programmable fuse macro. It drives the macro's control pins in a fixed order and keeps each pin state for a set time. A requester hands over a starting byte offset and a byte count in one cycle. The sequencer then does the following:

- It selects the macro with load asserted and programming disabled.
- For each byte it presents the 10-bit address and raises strobe.
- It captures the data byte while strobe is high and offers that byte on a valid/ready stream.
- It drops strobe only after the consumer has taken the byte.

When the last byte has been released, the pins go back to the standby pattern.

Each wait lasts one delay unit. The delay unit is a parameter given in clock cycles, usually the number of cycles in one microsecond. A single shared down-counter times every wait. The read granularity is one byte and any offset is allowed. The address wraps within 10 bits.

Top module: `efuse_rd_seq`

## Requirements
- R1: After reset the control word is the standby word 0x009 (bits 3 and 0 set), `busy` is low and `out_valid` is low.
- R2: Control word layout is fixed: bit 0 chip-select-bar, bit 1 strobe, bit 2 load, bit 3 program-enable-bar, bits 5:4 zero, bits 15:6 the fuse address. Strobe is never high while chip-select-bar is high.
- R3: After a request is accepted, the control word is 0x00C (load plus program-enable-bar, macro selected) for exactly DELAY_CYC cycles.
- R4: For each byte, the word 0x00C with the current address in bits 15:6 and strobe low is held for exactly DELAY_CYC cycles.
- R5: Strobe then rises with the address unchanged for exactly DELAY_CYC cycles. The byte on `fuse_dout` at the end of that window appears on `out_data` with `out_valid` high in the next cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and the strobe-high control word stay unchanged.
- R7: The cycle after a handshake, strobe falls and the address is kept for exactly DELAY_CYC cycles.
- R8: Successive bytes use offset, offset+1, and so on, wrapping from 1023 to 0. Exactly `req_count` bytes are emitted.
- R9: The cycle after the last release wait, the control word is the standby word 0x009 and `busy` is low.
- R10: A count of zero performs the preamble and then enters standby, with no byte emitted.
- R11: `busy` is high from the cycle after acceptance until standby. A request presented while busy is ignored and does not alter the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start request, accepted when not busy |
| req_offset | input | ADDR_W | First byte offset |
| req_count | input | COUNT_W | Number of bytes to read |
| busy | output | 1 | Run in progress |
| fuse_ctrl | output | ADDR_W+6 | Control word to the fuse macro |
| fuse_dout | input | 8 | Data byte from the fuse macro |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Captured byte |

## Verification
The bench sweeps offsets near both ends of the address space, counts from zero to four and several stall lengths. It checks the control word on every cycle of each run against a trace computed from the delay unit.

- A design that ends a wait one cycle early or late breaks a phase-length check.
- A design that samples data before the strobe window ends returns the byte for the wrong moment, because the fuse model gives zero while strobe is low.
- A design that releases strobe during a stall shows up as a changed word before the handshake.
- Runs that start at 1021 and 1023 catch an address that fails to wrap or that carries into bit 16.
- A request held high throughout a run catches a sequencer that restarts, or takes the new offset, while busy.

// File: rtl/efuse_rd_pkg.sv
// Shared definitions for the fuse read sequencer: control-word bit
// positions and the sequencer state encoding.
package efuse_rd_pkg;
    localparam int BIT_CSB   = 0;
    localparam int BIT_STRB  = 1;
    localparam int BIT_LOAD  = 2;
    localparam int BIT_PGENB = 3;
    localparam int ADDR_LSB  = 6;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ADDR = 3'd2,
        ST_STRB = 3'd3,
        ST_HOLD = 3'd4,
        ST_REL  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/efuse_wait_timer.sv
// Shared down-counter that times every wait of the sequencer.
// Assumes DELAY_CYC >= 1. A load makes `expired` rise exactly
// DELAY_CYC cycles later, measured in the owning state.
module efuse_wait_timer #(
    parameter int DELAY_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= RELOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    p_timer_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RELOAD);
    p_timer_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/efuse_ctrl_enc.sv
// Maps the sequencer state and current address to the macro control
// word. Purely combinational; assumes the package bit positions.
module efuse_ctrl_enc
    import efuse_rd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  seq_state_t           state,
    input  logic [ADDR_W-1:0]    addr,
    output logic [ADDR_LSB+ADDR_W-1:0] ctrl
);
    localparam int CTRL_W = ADDR_LSB + ADDR_W;

    // Build the pin pattern for each phase.
    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_IDLE: begin
                ctrl[BIT_PGENB] = 1'b1;
                ctrl[BIT_CSB]   = 1'b1;
            end
            ST_PRE: begin
                ctrl[BIT_PGENB] = 1'b1;
                ctrl[BIT_LOAD]  = 1'b1;
            end
            ST_ADDR, ST_REL: begin
                ctrl[BIT_PGENB] = 1'b1;
                ctrl[BIT_LOAD]  = 1'b1;
                ctrl[CTRL_W-1:ADDR_LSB] = addr;
            end
            ST_STRB, ST_HOLD: begin
                ctrl[BIT_PGENB] = 1'b1;
                ctrl[BIT_LOAD]  = 1'b1;
                ctrl[BIT_STRB]  = 1'b1;
                ctrl[CTRL_W-1:ADDR_LSB] = addr;
            end
            default: begin
                ctrl[BIT_PGENB] = 1'b1;
                ctrl[BIT_CSB]   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/efuse_rd_fsm.sv
// Phase sequencer: accepts a request, steps through preamble, address
// setup, strobe, output hold and release per byte, then standby.
// Assumes the wait timer asserts `tmr_done` one delay unit after a load.
module efuse_rd_fsm
    import efuse_rd_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int COUNT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_offset,
    input  logic [COUNT_W-1:0] req_count,
    input  logic               tmr_done,
    output logic               tmr_load,
    input  logic [7:0]         fuse_dout,
    output seq_state_t         state,
    output logic [ADDR_W-1:0]  addr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data
);
    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

    seq_state_t         nxt;
    logic [COUNT_W-1:0] remain;

    // Next-state and timer-reload decode.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                nxt = ST_PRE; tmr_load = 1'b1;
            end
            ST_PRE: if (tmr_done) begin
                if (remain == '0) nxt = ST_IDLE;
                else begin nxt = ST_ADDR; tmr_load = 1'b1; end
            end
            ST_ADDR: if (tmr_done) begin
                nxt = ST_STRB; tmr_load = 1'b1;
            end
            ST_STRB: if (tmr_done) nxt = ST_HOLD;
            ST_HOLD: if (out_ready) begin
                nxt = ST_REL; tmr_load = 1'b1;
            end
            ST_REL: if (tmr_done) begin
                if (remain == ONE) nxt = ST_IDLE;
                else begin nxt = ST_ADDR; tmr_load = 1'b1; end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Address and remaining-count bookkeeping per run and per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            addr   <= req_offset;
            remain <= req_count;
        end else if (state == ST_REL && tmr_done) begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    // Capture at the end of the strobe window, clear on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (state == ST_STRB && tmr_done) begin
            out_valid <= 1'b1;
            out_data  <= fuse_dout;
        end else if (state == ST_HOLD && out_ready) begin
            out_valid <= 1'b0;
        end
    end

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    p_no_run_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_REL) |=> $stable(addr));
endmodule

// File: rtl/efuse_rd_seq.sv
// Top of the fuse read sequencer. Joins the phase sequencer, the shared
// wait timer and the control-word encoder. Assumes the fuse macro is
// combinational from strobe to data within one delay unit.
module efuse_rd_seq
    import efuse_rd_pkg::*;
#(
    parameter int DELAY_CYC = 50,
    parameter int ADDR_W    = 10,
    parameter int COUNT_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_offset,
    input  logic [COUNT_W-1:0]         req_count,
    output logic                       busy,
    output logic [ADDR_LSB+ADDR_W-1:0] fuse_ctrl,
    input  logic [7:0]                 fuse_dout,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [7:0]                 out_data
);
    localparam int CTRL_W = ADDR_LSB + ADDR_W;

    seq_state_t        state;
    logic [ADDR_W-1:0] addr;
    logic              tmr_load;
    logic              tmr_done;

    efuse_wait_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_done)
    );

    efuse_rd_fsm #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_offset (req_offset),
        .req_count  (req_count),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .fuse_dout  (fuse_dout),
        .state      (state),
        .addr       (addr),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data)
    );

    efuse_ctrl_enc #(.ADDR_W(ADDR_W)) u_enc (
        .state (state),
        .addr  (addr),
        .ctrl  (fuse_ctrl)
    );

    assign busy = (state != ST_IDLE);

    p_strobe_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_ctrl[BIT_STRB] |-> !fuse_ctrl[BIT_CSB]);
    p_strobe_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_ctrl[BIT_STRB] && $past(fuse_ctrl[BIT_STRB]))
        |-> $stable(fuse_ctrl[CTRL_W-1:ADDR_LSB]));
    p_idle_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fuse_ctrl[BIT_PGENB] && fuse_ctrl[BIT_CSB]
                   && !fuse_ctrl[BIT_LOAD] && !fuse_ctrl[BIT_STRB]));
    p_valid_under_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fuse_ctrl[BIT_STRB]);
endmodule

// File: tb/test_efuse_rd_seq.sv
// Self-checking bench: sweeps offsets, counts and stall lengths and
// compares every cycle of the control word to a computed trace.
module test_efuse_rd_seq;
    localparam int D  = 3;
    localparam int AW = 10;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_offset = '0;
    logic [CW-1:0] req_count = '0;
    logic          busy;
    logic [15:0]   fuse_ctrl;
    logic [7:0]    fuse_dout;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    efuse_rd_seq #(.DELAY_CYC(D), .ADDR_W(AW), .COUNT_W(CW)) i_efuse_rd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_count(req_count), .busy(busy), .fuse_ctrl(fuse_ctrl),
        .fuse_dout(fuse_dout), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    function automatic logic [7:0] pat(input logic [9:0] a);
        logic [7:0] hi;
        hi = {6'd0, a[9:8]};
        return a[7:0] * 8'd37 + hi * 8'd91 + 8'd5;
    endfunction

    // Fuse macro model: data only while selected and strobed.
    assign fuse_dout = (fuse_ctrl[1] && !fuse_ctrl[0]) ? pat(fuse_ctrl[15:6]) : 8'h00;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] word(input logic [9:0] a, input bit strb);
        return {a, 6'b000100} | (strb ? 16'h0002 : 16'h0000) | 16'h0008;
    endfunction

    task automatic run(input logic [9:0] off, input int cnt, input int stall, input bit spam);
        @(negedge clk);
        req_valid = 1'b1; req_offset = off; req_count = CW'(cnt);
        for (int i = 0; i < D; i++) begin
            @(negedge clk);
            if (i == 0) begin
                if (spam) begin req_offset = off + 10'd77; req_count = CW'(cnt + 5); end
                else req_valid = 1'b0;
                chk(busy == 1'b1, "R11 busy after accept", 32'(busy), 1);
            end
            chk(fuse_ctrl == 16'h000C, "R3 preamble word", 32'(fuse_ctrl), 32'h000C);
        end
        for (int b = 0; b < cnt; b++) begin
            logic [9:0] a;
            a = off + 10'(b);
            for (int i = 0; i < D; i++) begin
                @(negedge clk);
                chk(fuse_ctrl == word(a, 0), "R4 R8 address setup", 32'(fuse_ctrl), 32'(word(a, 0)));
                chk(!out_valid, "R4 no output during setup", 32'(out_valid), 0);
            end
            for (int i = 0; i < D; i++) begin
                @(negedge clk);
                chk(fuse_ctrl == word(a, 1), "R5 strobe word", 32'(fuse_ctrl), 32'(word(a, 1)));
                chk(!out_valid, "R5 output not early", 32'(out_valid), 0);
            end
            @(negedge clk);
            chk(out_valid && out_data == pat(a), "R5 captured byte", {23'd0, out_valid, out_data},
                {23'd0, 1'b1, pat(a)});
            for (int k = 0; k < stall; k++) begin
                @(negedge clk);
                chk(out_valid && out_data == pat(a) && fuse_ctrl == word(a, 1), "R6 stall hold",
                    {7'd0, out_valid, out_data, fuse_ctrl}, {7'd0, 1'b1, pat(a), word(a, 1)});
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            chk(!out_valid && fuse_ctrl == word(a, 0), "R7 release word",
                {15'd0, out_valid, fuse_ctrl}, {15'd0, 1'b0, word(a, 0)});
            for (int i = 1; i < D; i++) begin
                @(negedge clk);
                chk(fuse_ctrl == word(a, 0), "R7 release length", 32'(fuse_ctrl), 32'(word(a, 0)));
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(fuse_ctrl == 16'h0009 && !busy && !out_valid,
            cnt == 0 ? "R10 zero count standby" : "R9 standby after run",
            {14'd0, out_valid, busy, fuse_ctrl}, 32'h0009);
        @(negedge clk);
        chk(fuse_ctrl == 16'h0009 && !busy, "R11 no restart after run",
            {15'd0, busy, fuse_ctrl}, 32'h0009);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(fuse_ctrl == 16'h0009 && !busy && !out_valid, "R1 reset state",
            {14'd0, out_valid, busy, fuse_ctrl}, 32'h0009);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fuse_ctrl == 16'h0009, "R1 R2 idle word", 32'(fuse_ctrl), 32'h0009);
        begin
            logic [9:0] offs [5];
            offs = '{10'd0, 10'd1, 10'd517, 10'd1021, 10'd1023};
            foreach (offs[o]) begin
                for (int c = 0; c <= 4; c++) begin
                    run(offs[o], c, (o + c) % 3, (o + c) % 2 == 1);
                end
            end
        end
        run(10'd1022, 6, 4, 1'b1);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule